// File: doc/BRIEF.md
# Fractional-Rate Pulse Width Modulator

This block produces one pulse-width-modulated output from a single 32-bit control word. A 16-bit phase accumulator adds a programmable step on every enabled clock. The output period is therefore 65536/step clocks, and the output frequency is the clock frequency times step/65536. Steps that do not divide 65536 give fractional periods whose length is averaged over many cycles. The output is high while the upper byte of the phase is at or above a threshold byte. The threshold is stored inverted: 0 gives an output that is almost always high, and 255 gives one that is almost always low.

Software writes the step and threshold into a shadow copy and sets an update-request bit. The shadow values reach the active copy only when the accumulator wraps, so no period is ever cut short or mixed. While the block is disabled, the transfer takes place one clock after the request. The register port is a plain one-cycle write strobe with a combinational read. It is a control path, so it carries no valid/ready handshake and never applies back-pressure.

Top module: `pwm_frac_top`

## Requirements
- R1: After reset the read word is 0x00000000 and the output is low.
- R2: Writing the enable bit (bit 31) as 0 forces the output low from the next clock and zeroes the phase. After the enable is set again, the phase restarts from zero with the active settings, so the first high level comes after threshold*256/step clocks.
- R3: Word layout: bit 31 enable, bit 30 update request, bits 23:8 step, bits 7:0 threshold. A read returns the enable, the pending flag and the shadow values, with bits 29:24 reading 0.
- R4: A written step above 0x8002 is stored as 0x8002. The value 0x8002 and all smaller values are stored unchanged.
- R5: While enabled, the phase advances by the active step each clock modulo 65536. With a step of 0x1000 the output repeats every 16 clocks.
- R6: The output is high exactly when the block is enabled and phase[15:8] >= the active threshold. With step 0x0100 and threshold 0xFF it is high 1 clock in 256.
- R7: While enabled, a write with bit 30 set leaves bit 30 reading 1 until the next phase wrap. At that wrap the shadow step and threshold become active and bit 30 clears in the same clock.
- R8: While disabled, a pending update is applied on the next clock and bit 30 then reads 0.
- R9: A write with bit 30 clear changes only the shadow copy; the output waveform keeps using the active settings.
- R10: An active step of 0 freezes the phase. The output then stays high if the threshold is 0 and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Control word read-back |
| pwm_out | output | 1 | Modulated output |

## Verification
A step of 0x1000 with a mid-scale threshold gives an exact 16-clock period and a 50% duty. It also gives a known delay from enable to the first high level, which shows whether the phase restarted from zero. A step of 0x2000 with threshold 0x40, loaded through a pending update, gives a 75% duty that can be told apart from the old setting only if the transfer took place. The extremes are also tried: threshold 0 at the maximum step, threshold 0xFF with a slow step that is high once in 256 clocks, and a zero step with both threshold cases. These separate an off-by-one compare from a correct one and a frozen phase from a running one. A cycle-by-cycle reference model checks every output sample and every read word across all of these patterns.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  localparam int EN_POS = 31;
  localparam int UPD_POS = 30;
  localparam int unsigned DEF_STEP_MAX = 32'h0000_8002;
endpackage

// File: rtl/pwm_frac_regs.sv
module pwm_frac_regs #(
  parameter int ACC_W = 16,
  parameter int DIV_W = 8,
  parameter int unsigned STEP_MAX = pwm_frac_pkg::DEF_STEP_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  input  logic             wrap_i,
  output logic             en_o,
  output logic             stop_o,
  output logic [ACC_W-1:0] step_o,
  output logic [DIV_W-1:0] thr_o,
  output logic [31:0]      rd_data_o
);
  import pwm_frac_pkg::*;

  localparam int STEP_LO = DIV_W;
  localparam int STEP_HI = DIV_W + ACC_W - 1;
  localparam logic [ACC_W-1:0] LIM = ACC_W'(STEP_MAX);

  logic             en_q, pend_q, xfer;
  logic [ACC_W-1:0] sh_step_q, act_step_q, wr_step, wr_step_sat;
  logic [DIV_W-1:0] sh_thr_q, act_thr_q;

  assign wr_step     = wr_data_i[STEP_LO +: ACC_W];
  assign wr_step_sat = (wr_step > LIM) ? LIM : wr_step;
  // load shadow on a wrap, or at once when idle
  assign xfer        = pend_q & (~en_q | wrap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
      sh_step_q  <= '0;
      sh_thr_q   <= '0;
      act_step_q <= '0;
      act_thr_q  <= '0;
    end else begin
      if (xfer) begin
        act_step_q <= sh_step_q;
        act_thr_q  <= sh_thr_q;
      end
      if (wr_en_i) begin
        en_q      <= wr_data_i[EN_POS];
        sh_step_q <= wr_step_sat;
        sh_thr_q  <= wr_data_i[DIV_W-1:0];
      end
      if (wr_en_i && wr_data_i[UPD_POS]) pend_q <= 1'b1;
      else if (xfer)                     pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o                     = '0;
    rd_data_o[EN_POS]             = en_q;
    rd_data_o[UPD_POS]            = pend_q;
    rd_data_o[STEP_LO +: ACC_W]   = sh_step_q;
    rd_data_o[DIV_W-1:0]          = sh_thr_q;
  end

  assign en_o   = en_q;
  assign stop_o = wr_en_i & ~wr_data_i[EN_POS];
  assign step_o = act_step_q;
  assign thr_o  = act_thr_q;

  generate
    if (STEP_HI < UPD_POS - 1) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^wr_data_i[UPD_POS-1:STEP_HI+1];
    end
  endgenerate

  // R4: shadow step never above the ceiling
  a_r4_step_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_step_q <= LIM);
  // R7: pending flag drops only through a transfer
  a_r7_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(xfer));
  // R9: active settings hold without a transfer
  a_r9_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> ($stable(act_step_q) && $stable(act_thr_q)));
endmodule

// File: rtl/pwm_frac_accum.sv
module pwm_frac_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stop_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, step_i};
  assign wrap_o = en_i & sum[ACC_W];
  assign phase_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               acc_q <= '0;
    else if (!en_i || stop_i)  acc_q <= '0;
    else                       acc_q <= sum[ACC_W-1:0];
  end

  // R2: a fresh enable always starts at phase zero
  a_r2_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> acc_q == '0);
  // R10: zero step freezes the phase
  a_r10_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stop_i && step_i == '0) |=> $stable(acc_q));
endmodule

// File: rtl/pwm_frac_cmp.sv
module pwm_frac_cmp #(
  parameter int ACC_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             en_i,
  input  logic [ACC_W-1:0] phase_i,
  input  logic [DIV_W-1:0] thr_i,
  output logic             pwm_o
);
  logic [DIV_W-1:0] phase_hi;
  assign phase_hi = phase_i[ACC_W-1 -: DIV_W];
  assign pwm_o    = en_i & (phase_hi >= thr_i);
endmodule

// File: rtl/pwm_frac_top.sv
module pwm_frac_top #(
  parameter int ACC_W = 16,
  parameter int DIV_W = 8,
  parameter int unsigned STEP_MAX = pwm_frac_pkg::DEF_STEP_MAX
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        pwm_out
);
  logic             en, stop, wrap;
  logic [ACC_W-1:0] step, phase;
  logic [DIV_W-1:0] thr;

  pwm_frac_regs #(.ACC_W(ACC_W), .DIV_W(DIV_W), .STEP_MAX(STEP_MAX)) u_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(reg_we), .wr_data_i(reg_wdata),
    .wrap_i(wrap), .en_o(en), .stop_o(stop), .step_o(step), .thr_o(thr),
    .rd_data_o(reg_rdata));

  pwm_frac_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .stop_i(stop), .step_i(step),
    .phase_o(phase), .wrap_o(wrap));

  pwm_frac_cmp #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_cmp (
    .en_i(en), .phase_i(phase), .thr_i(thr), .pwm_o(pwm_out));
endmodule

// File: tb/tb_pwm_frac_top.sv
module tb_pwm_frac_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  pwm_frac_top dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out));

  // reference model written from the requirements
  logic        m_en, m_pend;
  logic [15:0] m_sh_step, m_act_step, m_acc;
  logic [7:0]  m_sh_thr, m_act_thr;
  logic        q_out[$];
  logic [31:0] q_rd[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_pend <= 0; m_sh_step <= 0; m_act_step <= 0;
      m_acc <= 0; m_sh_thr <= 0; m_act_thr <= 0;
    end else begin
      logic wr_wrap, wr_xfer;
      logic [15:0] ws;
      wr_wrap = m_en && ({1'b0, m_acc} + {1'b0, m_act_step} > 17'h0FFFF);
      wr_xfer = m_pend && (!m_en || wr_wrap);
      if (wr_xfer) begin m_act_step <= m_sh_step; m_act_thr <= m_sh_thr; end
      ws = reg_wdata[23:8];
      if (reg_we) begin
        m_en <= reg_wdata[31];
        m_sh_step <= (ws > 16'h8002) ? 16'h8002 : ws;
        m_sh_thr <= reg_wdata[7:0];
      end
      if (reg_we && reg_wdata[30]) m_pend <= 1;
      else if (wr_xfer) m_pend <= 0;
      if (!m_en || (reg_we && !reg_wdata[31])) m_acc <= 0;
      else m_acc <= m_acc + m_act_step;
    end
  end

  // driver side of the scoreboard: push what the model expects
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      q_out.push_back(m_en && (m_acc[15:8] >= m_act_thr));
      q_rd.push_back({m_en, m_pend, 6'b0, m_sh_step, m_sh_thr});
    end
  end

  // monitor: pop and compare
  always @(posedge clk) begin
    #5;
    if (rst_n && q_out.size() > 0) begin
      logic eo;
      logic [31:0] er;
      eo = q_out.pop_front();
      er = q_rd.pop_front();
      n_run++;
      if (pwm_out !== eo) begin
        n_fail++;
        $display("FAIL R6 scoreboard output: got %0b exp %0b", pwm_out, eo);
      end
      n_run++;
      if (reg_rdata !== er) begin
        n_fail++;
        $display("FAIL R3 scoreboard readback: got %h exp %h", reg_rdata, er);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); reg_we = 1'b1; reg_wdata = w;
    @(negedge clk); reg_we = 1'b0;
  endtask

  function automatic logic [31:0] word(input logic en, input logic upd,
                                       input logic [15:0] s, input logic [7:0] t);
    return {en, upd, 6'b0, s, t};
  endfunction

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_up();
  end

  initial begin
    int c, n, p;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset read", reg_rdata, 32'h0);
    chk("R1 reset out", {31'b0, pwm_out}, 32'h0);

    // R4 saturation, R8 idle update
    wr(word(0, 1, 16'hFFFF, 8'h80));
    chk("R4 step 0xFFFF saturates", {16'b0, reg_rdata[23:8]}, 32'h8002);
    chk("R8 pending while idle", {31'b0, reg_rdata[30]}, 32'h1);
    @(negedge clk);
    chk("R8 idle update applied", {31'b0, reg_rdata[30]}, 32'h0);
    wr(word(0, 1, 16'h8003, 8'h00));
    chk("R4 step 0x8003 saturates", {16'b0, reg_rdata[23:8]}, 32'h8002);
    wr(word(0, 1, 16'h8002, 8'h00));
    chk("R4 step 0x8002 kept", {16'b0, reg_rdata[23:8]}, 32'h8002);
    wr(word(0, 1, 16'h7FFF, 8'h00));
    chk("R4 step 0x7FFF kept", {16'b0, reg_rdata[23:8]}, 32'h7FFF);

    // R6 threshold 0 at maximum step: always high
    wr(word(0, 1, 16'h8002, 8'h00)); idle(2);
    wr(word(1, 0, 16'h8002, 8'h00));
    count_high(64, c);
    chk("R6 threshold 0 high count", c, 64);

    // R2 restart, R5 period
    wr(word(0, 1, 16'h1000, 8'h80));
    chk("R2 output low after disable", {31'b0, pwm_out}, 32'h0);
    idle(2);
    wr(word(1, 0, 16'h1000, 8'h80));
    n = 0;
    while (!pwm_out && n < 100) begin @(negedge clk); n++; end
    chk("R2 clocks to first high after restart", n, 8);
    p = 0;
    while (pwm_out && p < 100) begin @(negedge clk); p++; end
    while (!pwm_out && p < 100) begin @(negedge clk); p++; end
    chk("R5 period with step 0x1000", p, 16);
    count_high(64, c);
    chk("R6 half duty", c, 32);

    // R9 shadow-only write
    wr(word(1, 0, 16'h2000, 8'h10));
    chk("R9 shadow readback", reg_rdata, 32'h8020_0010);
    count_high(64, c);
    chk("R9 waveform unchanged", c, 32);

    // R7 update at wrap
    wr(word(1, 1, 16'h2000, 8'h40));
    chk("R7 pending after request", {31'b0, reg_rdata[30]}, 32'h1);
    n = 0;
    while (reg_rdata[30] && n < 40) begin @(negedge clk); n++; end
    n_run++;
    if (n > 16) begin
      n_fail++;
      $display("FAIL R7 update latency: got %0d exp <= 16", n);
    end
    count_high(64, c);
    chk("R7 new duty active", c, 48);

    // R3 layout and spare bits
    wr(32'hFF00_2040);
    chk("R3 read word layout", reg_rdata, 32'hC000_2040);
    wr(word(0, 1, 16'h0100, 8'hFF));
    chk("R2 low on disable", {31'b0, pwm_out}, 32'h0);
    @(negedge clk);
    chk("R8 pending cleared next clock", {31'b0, reg_rdata[30]}, 32'h0);

    // R6 boundary threshold 0xFF
    wr(word(1, 0, 16'h0100, 8'hFF));
    count_high(256, c);
    chk("R6 threshold 0xFF high count", c, 1);

    // R10 zero step
    wr(word(0, 1, 16'h0000, 8'h00)); idle(2);
    wr(word(1, 0, 16'h0000, 8'h00));
    count_high(32, c);
    chk("R10 zero step threshold 0 high", c, 32);
    wr(word(0, 1, 16'h0000, 8'h05)); idle(2);
    wr(word(1, 0, 16'h0000, 8'h05));
    count_high(32, c);
    chk("R10 zero step threshold 5 low", c, 0);

    idle(2);
    finish_up();
  end
endmodule